// File: doc/BRIEF.md
# Program-Interrupt Trap Entry Unit

This unit sits at the end of instruction decode. For each valid instruction it decides whether the instruction must enter the program interrupt, stop the core, or just retire. It then updates the architectural state on one clock edge. The inputs are the current instruction address, the current machine state word and a few decode flags. The registered outputs are the next instruction address, the two save/restore registers, the new machine state word and a sticky halted flag.

An instruction is privileged in three cases: it belongs to the class of privileged operations, it is the attention (halt) operation, or it moves to or from a special register whose number has its high bit set. A privileged instruction that runs in problem state traps. This privilege check runs before the halt check and before the illegal-instruction check. A trap saves the current address and a copy of the machine state. That copy is tagged with a reason bit. The trap then rewrites the live machine state to a fixed supervisor setting and jumps to the program-interrupt vector. All machine-state bit positions are parameters and are given in MSB0 numbering, where bit 0 is the most significant bit of the 64-bit word.

Top module: `prog_trap_entry`

## Requirements
- R1: After synchronous reset, `nia_o` is 0, `srr0_o` and `srr1_o` are 0, `msr_o` is 0 and `halted_o` is 0.
- R2: An instruction is privileged when `priv_op_i` or `halt_op_i` is 1, or when both `spr_move_i` and `spr_hi_i` are 1. A special-register move with `spr_hi_i` = 0 is not privileged.
- R3: A privileged instruction with problem-state bit 49 (MSB0, i.e. bit 14 counted from the LSB) of `msr_i` at 1 traps. Then `nia_o` becomes 0x700 and `srr1_o` equals `msr_i` with bit 45 (MSB0, LSB bit 18) set.
- R4: A privilege trap takes priority over the halt and illegal checks. When a privileged instruction runs with the problem-state bit at 0, it does not trap.
- R5: When `halt_op_i` is 1 and no privilege trap occurs, `halted_o` becomes 1. `nia_o`, `srr0_o`, `srr1_o` and `msr_o` keep their values.
- R6: While `halted_o` is 1, valid instructions have no effect. Only reset clears the halted state.
- R7: An illegal instruction (`illegal_i` = 1, with no privilege trap and no halt) traps to 0x700. `srr1_o` equals `msr_i` with bit 44 (MSB0, LSB bit 19) set.
- R8: On any trap, `srr0_o` receives `cia_i`. The reason bit is set only in `srr1_o`.
- R9: On any trap, `msr_o` becomes `msr_i` with MSB0 bits 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 56, 58, 59, 61 and 62 cleared, and bits 0 and 63 set. All other bits pass through unchanged.
- R10: A valid instruction that neither traps nor halts sets `nia_o` to `cia_i` + 4 and `msr_o` to `msr_i`, and leaves `srr0_o` and `srr1_o` unchanged.
- R11: While `insn_valid_i` is 0, all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid_i | input | 1 | An instruction is presented this cycle |
| cia_i | input | 64 | Current instruction address |
| msr_i | input | 64 | Current machine state word |
| priv_op_i | input | 1 | Instruction is in the privileged operation class |
| spr_move_i | input | 1 | Instruction moves to or from a special register |
| spr_hi_i | input | 1 | High bit of the special-register number |
| illegal_i | input | 1 | Instruction failed decode |
| halt_op_i | input | 1 | Instruction is the attention (halt) operation |
| nia_o | output | 64 | Next instruction address |
| srr0_o | output | 64 | Saved address register |
| srr1_o | output | 64 | Saved machine state with trap reason |
| msr_o | output | 64 | New machine state word |
| halted_o | output | 1 | Core has halted |

## Verification
The assertions assume that `cia_i`, `msr_i` and the decode flags hold known values in every cycle after reset, whether or not `insn_valid_i` is high. They also assume that the parameterised bit positions are distinct and below the word width. Each test task drives every input to a defined value on the falling edge and raises `insn_valid_i` for exactly one cycle. Each task then returns the flags to zero, so a flag left over from one scenario cannot reach the next. The halt scenario runs last, and a reset follows it so that the sticky state is cleared under control.

// File: rtl/prog_trap_pkg.sv
package prog_trap_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_PRIV    = 2'd1,
    CAUSE_HALT    = 2'd2,
    CAUSE_ILLEGAL = 2'd3
  } cause_e;

  // Convert an MSB0 bit index into a conventional LSB index.
  function automatic int unsigned msb0_pos(input int unsigned width, input int unsigned p);
    return width - 1 - p;
  endfunction
endpackage

// File: rtl/trap_decide.sv
module trap_decide
  import prog_trap_pkg::*;
(
  input  logic   priv_op,
  input  logic   spr_move,
  input  logic   spr_hi,
  input  logic   illegal,
  input  logic   halt_op,
  input  logic   problem_state,
  output cause_e cause
);
  logic privileged;

  always_comb begin
    privileged = priv_op | halt_op | (spr_move & spr_hi);
    if (privileged && problem_state)
      cause = CAUSE_PRIV;
    else if (halt_op)
      cause = CAUSE_HALT;
    else if (illegal)
      cause = CAUSE_ILLEGAL;
    else
      cause = CAUSE_NONE;
  end
endmodule

// File: rtl/msr_rewrite.sv
module msr_rewrite
  import prog_trap_pkg::*;
#(
  parameter int unsigned MSR_W = 64,
  parameter int unsigned N_CLR = 15,
  parameter int unsigned CLR_POS [N_CLR] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 56, 58, 59, 61, 62},
  parameter int unsigned SF_POS = 0,
  parameter int unsigned LE_POS = 63
) (
  input  logic [MSR_W-1:0] msr_in,
  output logic [MSR_W-1:0] msr_out
);
  localparam int unsigned SF_L = msb0_pos(MSR_W, SF_POS);
  localparam int unsigned LE_L = msb0_pos(MSR_W, LE_POS);

  logic [MSR_W-1:0] clr_part [N_CLR+1];
  logic [MSR_W-1:0] set_mask;

  assign clr_part[0] = '0;
  for (genvar g = 0; g < N_CLR; g++) begin : g_clr
    localparam int unsigned BIT_L = msb0_pos(MSR_W, CLR_POS[g]);
    logic [MSR_W-1:0] one_bit;
    always_comb begin
      one_bit = '0;
      one_bit[BIT_L] = 1'b1;
    end
    assign clr_part[g+1] = clr_part[g] | one_bit;
  end

  always_comb begin
    set_mask = '0;
    set_mask[SF_L] = 1'b1;
    set_mask[LE_L] = 1'b1;
    msr_out = (msr_in & ~clr_part[N_CLR]) | set_mask;
  end
endmodule

// File: rtl/prog_trap_entry.sv
module prog_trap_entry
  import prog_trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned MSR_W = 64,
  parameter logic [63:0] VECTOR = 64'h700,
  parameter int unsigned STEP = 4,
  parameter logic [63:0] RESET_ADDR = 64'h0,
  parameter logic [63:0] RESET_MSR = 64'h0,
  parameter int unsigned PR_POS = 49,
  parameter int unsigned PRIV_RSN_POS = 45,
  parameter int unsigned ILL_RSN_POS = 44,
  parameter int unsigned SF_POS = 0,
  parameter int unsigned LE_POS = 63,
  parameter int unsigned N_CLR = 15,
  parameter int unsigned CLR_POS [N_CLR] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 56, 58, 59, 61, 62}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid_i,
  input  logic [ADDR_W-1:0] cia_i,
  input  logic [MSR_W-1:0]  msr_i,
  input  logic              priv_op_i,
  input  logic              spr_move_i,
  input  logic              spr_hi_i,
  input  logic              illegal_i,
  input  logic              halt_op_i,
  output logic [ADDR_W-1:0] nia_o,
  output logic [ADDR_W-1:0] srr0_o,
  output logic [MSR_W-1:0]  srr1_o,
  output logic [MSR_W-1:0]  msr_o,
  output logic              halted_o
);
  localparam int unsigned PR_L   = msb0_pos(MSR_W, PR_POS);
  localparam int unsigned PRIV_L = msb0_pos(MSR_W, PRIV_RSN_POS);
  localparam int unsigned ILL_L  = msb0_pos(MSR_W, ILL_RSN_POS);
  localparam logic [ADDR_W-1:0] VEC_A  = VECTOR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  cause_e           cause;
  logic [MSR_W-1:0] trap_msr;
  logic [MSR_W-1:0] reason_mask;

  trap_decide u_decide (
    .priv_op       (priv_op_i),
    .spr_move      (spr_move_i),
    .spr_hi        (spr_hi_i),
    .illegal       (illegal_i),
    .halt_op       (halt_op_i),
    .problem_state (msr_i[PR_L]),
    .cause         (cause)
  );

  msr_rewrite #(
    .MSR_W   (MSR_W),
    .N_CLR   (N_CLR),
    .CLR_POS (CLR_POS),
    .SF_POS  (SF_POS),
    .LE_POS  (LE_POS)
  ) u_rewrite (
    .msr_in  (msr_i),
    .msr_out (trap_msr)
  );

  always_comb begin
    reason_mask = '0;
    if (cause == CAUSE_PRIV) reason_mask[PRIV_L] = 1'b1;
    else                     reason_mask[ILL_L]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nia_o    <= RESET_ADDR[ADDR_W-1:0];
      srr0_o   <= '0;
      srr1_o   <= '0;
      msr_o    <= RESET_MSR[MSR_W-1:0];
      halted_o <= 1'b0;
    end else if (insn_valid_i && !halted_o) begin
      unique case (cause)
        CAUSE_NONE: begin
          nia_o <= cia_i + STEP_A;
          msr_o <= msr_i;
        end
        CAUSE_HALT: begin
          halted_o <= 1'b1;
        end
        default: begin
          nia_o  <= VEC_A;
          srr0_o <= cia_i;
          srr1_o <= msr_i | reason_mask;
          msr_o  <= trap_msr;
        end
      endcase
    end
  end
endmodule

// File: rtl/prog_trap_entry_chk.sv
module prog_trap_entry_chk
  import prog_trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned MSR_W = 64,
  parameter logic [63:0] VECTOR = 64'h700,
  parameter int unsigned STEP = 4,
  parameter int unsigned PR_POS = 49,
  parameter int unsigned PRIV_RSN_POS = 45,
  parameter int unsigned ILL_RSN_POS = 44,
  parameter int unsigned SF_POS = 0,
  parameter int unsigned LE_POS = 63
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_valid_i,
  input logic [ADDR_W-1:0] cia_i,
  input logic [MSR_W-1:0]  msr_i,
  input logic              priv_op_i,
  input logic              spr_move_i,
  input logic              spr_hi_i,
  input logic              illegal_i,
  input logic              halt_op_i,
  input logic [ADDR_W-1:0] nia_o,
  input logic [ADDR_W-1:0] srr0_o,
  input logic [MSR_W-1:0]  srr1_o,
  input logic [MSR_W-1:0]  msr_o,
  input logic              halted_o
);
  localparam int unsigned PR_L   = msb0_pos(MSR_W, PR_POS);
  localparam int unsigned PRIV_L = msb0_pos(MSR_W, PRIV_RSN_POS);
  localparam int unsigned ILL_L  = msb0_pos(MSR_W, ILL_RSN_POS);
  localparam int unsigned SF_L   = msb0_pos(MSR_W, SF_POS);
  localparam int unsigned LE_L   = msb0_pos(MSR_W, LE_POS);

  logic viol, go;
  assign viol = (priv_op_i | halt_op_i | (spr_move_i & spr_hi_i)) & msr_i[PR_L];
  assign go   = insn_valid_i & ~halted_o;

  // R3
  priv_trap_chk: assert property (@(posedge clk) disable iff (rst)
    go && viol |=> nia_o == VECTOR[ADDR_W-1:0] && srr1_o[PRIV_L] && srr0_o == $past(cia_i));

  // R4
  priv_over_halt_chk: assert property (@(posedge clk) disable iff (rst)
    go && viol |=> !halted_o);

  // R6
  halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> halted_o && $stable(nia_o) && $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o));

  // R9
  trap_msr_chk: assert property (@(posedge clk) disable iff (rst)
    go && (viol || (!halt_op_i && illegal_i)) |=> msr_o[SF_L] && msr_o[LE_L] && !msr_o[PR_L]);

  // R10
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    go && !viol && !halt_op_i && !illegal_i
      |=> nia_o == $past(cia_i) + ADDR_W'(STEP) && msr_o == $past(msr_i) && $stable(srr0_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !insn_valid_i |=> $stable(nia_o) && $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o) && $stable(halted_o));

  // R7
  ill_reason_chk: assert property (@(posedge clk) disable iff (rst)
    go && !viol && !halt_op_i && illegal_i |=> srr1_o[ILL_L] && nia_o == VECTOR[ADDR_W-1:0]);
endmodule

bind prog_trap_entry prog_trap_entry_chk #(
  .ADDR_W       (ADDR_W),
  .MSR_W        (MSR_W),
  .VECTOR       (VECTOR),
  .STEP         (STEP),
  .PR_POS       (PR_POS),
  .PRIV_RSN_POS (PRIV_RSN_POS),
  .ILL_RSN_POS  (ILL_RSN_POS),
  .SF_POS       (SF_POS),
  .LE_POS       (LE_POS)
) chk_i (.*);

// File: tb/prog_trap_entry_tb_top.sv
module prog_trap_entry_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid_i = 1'b0;
  logic [63:0] cia_i = '0;
  logic [63:0] msr_i = '0;
  logic        priv_op_i = 1'b0, spr_move_i = 1'b0, spr_hi_i = 1'b0;
  logic        illegal_i = 1'b0, halt_op_i = 1'b0;
  logic [63:0] nia_o, srr0_o, srr1_o, msr_o;
  logic        halted_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [63:0] PR_M   = 64'h1 << 14;
  localparam logic [63:0] PRIV_M = 64'h1 << 18;
  localparam logic [63:0] ILL_M  = 64'h1 << 19;
  localparam logic [63:0] VEC    = 64'h700;

  always #5 clk = ~clk;

  prog_trap_entry dut_i (.*);

  function automatic logic [63:0] exp_rewrite(input logic [63:0] m);
    int unsigned lsb [15] = '{32, 25, 23, 15, 14, 13, 11, 10, 9, 8, 7, 5, 4, 2, 1};
    logic [63:0] clr = '0;
    foreach (lsb[i]) clr[lsb[i]] = 1'b1;
    return (m & ~clr) | (64'h1 << 63) | 64'h1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one instruction for one cycle; return at the following falling edge.
  task automatic issue(input logic [63:0] a, input logic [63:0] m,
                       input logic po, input logic sm, input logic sh,
                       input logic il, input logic ht);
    @(negedge clk);
    cia_i = a; msr_i = m; priv_op_i = po; spr_move_i = sm; spr_hi_i = sh;
    illegal_i = il; halt_op_i = ht; insn_valid_i = 1'b1;
    @(negedge clk);
    insn_valid_i = 1'b0; priv_op_i = 0; spr_move_i = 0; spr_hi_i = 0;
    illegal_i = 0; halt_op_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 nia", nia_o, 64'h0);
    chk("R1 srr0", srr0_o, 64'h0);
    chk("R1 srr1", srr1_o, 64'h0);
    chk("R1 msr", msr_o, 64'h0);
    chk("R1 halted", {63'h0, halted_o}, 64'h0);
  endtask

  task automatic t_sequential();
    issue(64'h1000, 64'h8000_0000_0000_0001, 0, 0, 0, 0, 0);
    chk("R10 nia", nia_o, 64'h1004);
    chk("R10 msr", msr_o, 64'h8000_0000_0000_0001);
    chk("R10 srr0 kept", srr0_o, 64'h0);
    issue(64'hFFFF_FFFF_FFFF_FFFC, 64'h0123_4567_89AB_CDEF & ~PR_M, 0, 0, 0, 0, 0);
    chk("R10 nia wrap", nia_o, 64'h0);
    chk("R10 msr copy", msr_o, 64'h0123_4567_89AB_CDEF & ~PR_M);
  endtask

  task automatic t_spr_low();
    // R2: special-register move with the high number bit clear is not privileged
    issue(64'h2000, PR_M | 64'h5, 0, 1, 0, 0, 0);
    chk("R2 spr low nia", nia_o, 64'h2004);
    chk("R2 spr low srr1", srr1_o, 64'h0);
  endtask

  task automatic t_priv_trap();
    logic [63:0] m = 64'h0000_0000_0000_F00F | PR_M | (64'h1 << 32);
    issue(64'h3000, m, 0, 1, 1, 0, 0);
    chk("R3 nia", nia_o, VEC);
    chk("R3 srr1", srr1_o, m | PRIV_M);
    chk("R8 srr0", srr0_o, 64'h3000);
    chk("R9 msr", msr_o, exp_rewrite(m));
    chk("R8 msr reason clear", msr_o & PRIV_M, 64'h0);
  endtask

  task automatic t_supervisor();
    issue(64'h4000, 64'h00FF, 1, 0, 0, 0, 0);
    chk("R4 supervisor nia", nia_o, 64'h4004);
    chk("R4 supervisor srr0 kept", srr0_o, 64'h3000);
  endtask

  task automatic t_illegal();
    logic [63:0] m = 64'hFFFF_FFFF_FFFF_FFFF & ~PR_M & ~ILL_M & ~PRIV_M;
    issue(64'h5000, m, 0, 0, 0, 1, 0);
    chk("R7 nia", nia_o, VEC);
    chk("R7 srr1", srr1_o, m | ILL_M);
    chk("R8 srr0", srr0_o, 64'h5000);
    chk("R9 msr", msr_o, exp_rewrite(m));
  endtask

  task automatic t_priority();
    issue(64'h6000, PR_M, 1, 0, 0, 1, 0);
    chk("R4 priv over illegal srr1", srr1_o, PR_M | PRIV_M);
    issue(64'h6100, PR_M | 64'h2, 0, 0, 0, 1, 1);
    chk("R4 priv over halt halted", {63'h0, halted_o}, 64'h0);
    chk("R4 priv over halt nia", nia_o, VEC);
    chk("R4 priv over halt srr0", srr0_o, 64'h6100);
  endtask

  task automatic t_idle();
    @(negedge clk);
    cia_i = 64'hDEAD; msr_i = PR_M; priv_op_i = 1; illegal_i = 1;
    @(negedge clk); @(negedge clk);
    priv_op_i = 0; illegal_i = 0;
    chk("R11 nia", nia_o, VEC);
    chk("R11 srr0", srr0_o, 64'h6100);
  endtask

  task automatic t_halt();
    issue(64'h7000, 64'h0, 0, 0, 0, 1, 1);
    chk("R5 halted", {63'h0, halted_o}, 64'h1);
    chk("R5 nia kept", nia_o, VEC);
    chk("R5 srr0 kept", srr0_o, 64'h6100);
    issue(64'h7100, PR_M, 0, 0, 0, 1, 0);
    chk("R6 nia ignored", nia_o, VEC);
    chk("R6 srr0 ignored", srr0_o, 64'h6100);
    issue(64'h7200, 64'h0, 0, 0, 0, 0, 0);
    chk("R6 still halted", {63'h0, halted_o}, 64'h1);
    do_reset();
    chk("R1 halted cleared", {63'h0, halted_o}, 64'h0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_sequential();
    t_spr_low();
    t_priv_trap();
    t_supervisor();
    t_illegal();
    t_priority();
    t_idle();
    t_halt();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule